// File: doc/BRIEF.md
# Bidirectional Recirculating Serial Shift Register

The block is a static serial shift register of a configurable number of stages (32 by default) advanced by a single clock. One direction-control input chooses, edge by edge, whether the contents move toward the high end or toward the low end. Each direction has its own serial data input and its own serial data output. Software-free datapath logic uses it as a delay line, a serial-to-serial buffer or a rotating pattern store.

A hold input freezes the whole register for as long as it is high. A recirculate input turns the shift into a rotation: the bit leaving one end enters at the other end, and the serial input for the active direction is ignored. Every serial output is a stage flop, so the outputs are registered.

Top module: `bishift_ring`

## Requirements
- R1: A synchronous active-high reset clears every stage to 0; reset takes priority over hold and every other input, and both serial outputs read 0 in the cycle after a reset edge.
- R2: With dir_right=0 (shift toward the high end), hold=0 and recirc=0, each clock edge moves stage k into stage k+1, loads sin_lft into stage 0; sout_lft shows stage 31, so a bit applied on sin_lft appears on sout_lft after 32 such edges.
- R3: With dir_right=1 (shift toward the low end), hold=0 and recirc=0, each clock edge moves stage k into stage k-1, loads sin_rgt into stage 31; sout_rgt shows stage 0, so a bit applied on sin_rgt appears on sout_rgt after 32 such edges.
- R4: dir_right is sampled on the same edge as the shift it controls; the direction may change on any edge without losing or duplicating a bit.
- R5: While hold=1 (and reset is low) no stage changes, whatever the values on dir_right, recirc, sin_lft and sin_rgt.
- R6: With recirc=1 and dir_right=0, stage 31 enters stage 0 and sin_lft is ignored.
- R7: With recirc=1 and dir_right=1, stage 0 enters stage 31 and sin_rgt is ignored.
- R8: Thirty-two rotations in one direction with recirc=1 leave the register holding its starting contents.
- R9: The serial input of the inactive direction never affects the contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all stages |
| hold | input | 1 | Freezes the contents while high |
| dir_right | input | 1 | 0: move toward stage 31; 1: move toward stage 0 |
| recirc | input | 1 | 1: rotate instead of taking the serial input |
| sin_lft | input | 1 | Serial input entering stage 0 on a shift toward the high end |
| sin_rgt | input | 1 | Serial input entering stage 31 on a shift toward the low end |
| sout_lft | output | 1 | Stage 31 |
| sout_rgt | output | 1 | Stage 0 |

## Verification
The bench targets the end stages: a design that wired the entering bit to the wrong end, or took the inactive serial input, would show a wrong bit on the far output exactly 32 edges later, which a full shift-out after each phase exposes. Direction flips on consecutive edges catch a design that registers the direction a cycle late and so moves a bit the wrong way once. Rotation for 32 edges followed by a read-out catches an off-by-one in the wrap path, and hold combined with active serial inputs and with reset catches wrong priority between freeze, reset and shifting.

// File: rtl/bishift_pkg.sv
package bishift_pkg;
  localparam int unsigned BS_STAGES = 32;

  typedef enum logic {
    BS_TOWARD_HI = 1'b0,
    BS_TOWARD_LO = 1'b1
  } bs_dir_e;
endpackage

// File: rtl/bishift_feed.sv
module bishift_feed (
  input  logic recirc,
  input  logic sin_lft,
  input  logic sin_rgt,
  input  logic top_bit,
  input  logic bot_bit,
  output logic enter_lo,
  output logic enter_hi
);
  always_comb begin
    enter_lo = recirc ? top_bit : sin_lft;
    enter_hi = recirc ? bot_bit : sin_rgt;
  end
endmodule

// File: rtl/bishift_row.sv
module bishift_row
  import bishift_pkg::*;
#(
  parameter int unsigned STAGES = BS_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  bs_dir_e           dir,
  input  logic              enter_lo,
  input  logic              enter_hi,
  output logic [STAGES-1:0] q
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic from_below;
    logic from_above;

    if (i == 0) begin : g_lo_end
      assign from_below = enter_lo;
    end else begin : g_lo_mid
      assign from_below = q[i-1];
    end

    if (i == LAST) begin : g_hi_end
      assign from_above = enter_hi;
    end else begin : g_hi_mid
      assign from_above = q[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= 1'b0;
      end else if (advance) begin
        q[i] <= (dir == BS_TOWARD_LO) ? from_above : from_below;
      end
    end
  end

  // R5
  freeze_row_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(q));
endmodule

// File: rtl/bishift_ring.sv
module bishift_ring
  import bishift_pkg::*;
#(
  parameter int unsigned STAGES = BS_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic dir_right,
  input  logic recirc,
  input  logic sin_lft,
  input  logic sin_rgt,
  output logic sout_lft,
  output logic sout_rgt
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stages;
  logic              enter_lo;
  logic              enter_hi;
  bs_dir_e           dir;

  assign dir = bs_dir_e'(dir_right);

  bishift_feed u_feed (
    .recirc   (recirc),
    .sin_lft  (sin_lft),
    .sin_rgt  (sin_rgt),
    .top_bit  (stages[LAST]),
    .bot_bit  (stages[0]),
    .enter_lo (enter_lo),
    .enter_hi (enter_hi)
  );

  bishift_row #(.STAGES(STAGES)) u_row (
    .clk      (clk),
    .rst      (rst),
    .advance  (!hold),
    .dir      (dir),
    .enter_lo (enter_lo),
    .enter_hi (enter_hi),
    .q        (stages)
  );

  assign sout_lft = stages[LAST];
  assign sout_rgt = stages[0];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!sout_lft && !sout_rgt));

  // R2
  hi_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !dir_right && !recirc) |=> (sout_rgt == $past(sin_lft)));

  // R3
  lo_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && dir_right && !recirc) |=> (sout_lft == $past(sin_rgt)));

  // R5
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(sout_lft) && $stable(sout_rgt)));

  // R6
  wrap_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !dir_right && recirc) |=> (sout_rgt == $past(sout_lft)));

  // R7
  wrap_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && dir_right && recirc) |=> (sout_lft == $past(sout_rgt)));
endmodule

// File: tb/sim_bishift_ring.sv
module sim_bishift_ring;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold = 1'b0;
  logic dir_right = 1'b0;
  logic recirc = 1'b0;
  logic sin_lft = 1'b0;
  logic sin_rgt = 1'b0;
  logic sout_lft;
  logic sout_rgt;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [N-1:0] m = '0;

  always #5 clk = ~clk;

  bishift_ring #(.STAGES(N)) u0 (
    .clk(clk), .rst(rst), .hold(hold), .dir_right(dir_right),
    .recirc(recirc), .sin_lft(sin_lft), .sin_rgt(sin_rgt),
    .sout_lft(sout_lft), .sout_rgt(sout_rgt)
  );

  function automatic logic [N-1:0] model_next(
    input logic [N-1:0] cur, input logic r, input logic h, input logic d,
    input logic rc, input logic sl, input logic sr);
    if (r) return '0;
    if (h) return cur;
    if (!d) return {cur[N-2:0], rc ? cur[N-1] : sl};
    return {rc ? cur[0] : sr, cur[N-1:1]};
  endfunction

  task automatic check(input string tag);
    total++;
    if (sout_lft !== m[N-1] || sout_rgt !== m[0]) begin
      bad++;
      $display("FAIL %s: outputs lft/rgt=%b%b expected %b%b", tag,
               sout_lft, sout_rgt, m[N-1], m[0]);
    end
  endtask

  // called at a negedge; returns at the next negedge after one rising edge
  task automatic step(input logic r, input logic h, input logic d,
                      input logic rc, input logic sl, input logic sr,
                      input string tag);
    rst = r; hold = h; dir_right = d; recirc = rc; sin_lft = sl; sin_rgt = sr;
    @(posedge clk);
    m = model_next(m, r, h, d, rc, sl, sr);
    @(negedge clk);
    check(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat;
    logic [N-1:0] seen;
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R1 reset");

    // R2: fill from the low end with a known pattern
    pat = 32'hA5C3_0F96;
    for (int i = N - 1; i >= 0; i--) step(1'b0, 1'b0, 1'b0, 1'b0, pat[i], ~pat[i], "R2 fill toward high end R9");
    // R5: hold with busy inputs
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, i[0], i[1], 1'b1, 1'b1, "R5 hold");
    // R8/R6: 32 rotations toward the high end, then read out toward low end
    for (int i = 0; i < N; i++) step(1'b0, 1'b0, 1'b0, 1'b1, ~m[N-1], 1'b1, "R6 rotate high");
    for (int i = 0; i < N; i++) begin
      seen[i] = sout_rgt;
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 read out R9");
    end
    total++;
    if (seen !== pat) begin
      bad++;
      $display("FAIL R8 rotate-high restore: got %h expected %h", seen, pat);
    end
    // R3 fill from high end, then R7 rotation and readout toward high end
    pat = 32'h3C69_E14B;
    for (int i = 0; i < N; i++) step(1'b0, 1'b0, 1'b1, 1'b0, ~pat[i], pat[i], "R3 fill toward low end");
    for (int i = 0; i < N; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, ~m[0], "R7 rotate low");
    for (int i = N - 1; i >= 0; i--) begin
      seen[i] = sout_lft;
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 read out");
    end
    total++;
    if (seen !== pat) begin
      bad++;
      $display("FAIL R8 rotate-low restore: got %h expected %h", seen, pat);
    end
    // R4: direction flips on consecutive edges
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, i[0], 1'b0, i[1], i[2], "R4 flip");
    // R1: reset wins over hold
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 load one");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R1 reset over hold");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic h, d, rc, r;
      r  = ($urandom % 200) == 0;
      h  = ($urandom % 5) == 0;
      d  = $urandom % 2;
      rc = ($urandom % 10) < 3;
      step(r, h, d, rc, $urandom % 2, $urandom % 2, "R2 R3 R5 R6 R7 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule